// File: doc/BRIEF.md
# Reset and Self-Test Start-Up Sequencer

This block brings a processor core out of reset. A raw active-low reset pin is first passed through a flop synchronizer. While the synchronized reset is active, the block holds the address/data and control pads at their idle values, keeps the run enable low and asserts the fail status line. Once reset is released, the block captures the self-test strap a single time. It then starts the test engines in order. When the strap is 1, the internal self-test runs first and the external bus confidence test follows. When the strap is 0, only the bus confidence test runs. Each engine is reached through a request/done/pass handshake.

The fail status line changes state at the start and at the end of every test. If every test passes, the line drops and the run enable rises, and the core pads then follow the core's own drive. If any test fails, the line stays high and the sequencer stops. It stays stopped until the next reset.

A separate width monitor measures each reset pulse. The first reset after power-good has been seen low is a cold reset and must last at least 10,000 cycles. Any other reset is warm and must last at least 15 cycles. A pulse shorter than its minimum raises a flag.

Top module: `rst_seq_top`

## Requirements
- R1: The raw reset reaches the sequencer through SYNC_STAGES (default 2) flops. Driving rst_n_i low while running leaves run_en_o high for 2 more cycles. On the third rising edge, fail_o becomes 1 and run_en_o, st_req_o and bt_req_o become 0.
- R2: pad_ad_o is AD_IDLE (default all 0) and pad_ctl_o is CTL_IDLE (default all 1) in every cycle after one in which run_en_o was low or reset was active. While running, the pads equal core_ad_i and core_ctl_i from the previous cycle.
- R3: st_en_i is captured exactly once, on the first edge after the synchronized reset releases. Later changes to it do not change the test path.
- R4: With the captured strap at 1, st_req_o is served first and bt_req_o after it. With the strap at 0, st_req_o never rises.
- R5: A request stays high until its done input is seen. Done and pass inputs are ignored while their request is low, including throughout reset.
- R6: fail_o is 1 at the release of reset. It toggles on the edge where a request rises and again on the edge where that request's done is accepted. A full pass therefore gives 5 transitions with the strap at 1 and 3 with the strap at 0, counting the final drop.
- R7: When the bus test passes, fail_o goes to 0 and run_en_o to 1 one cycle after done is accepted. Both hold until the next reset.
- R8: On any failing test, fail_o stays 1 and run_en_o stays 0, and no further request is issued until the next reset. A failing self-test gives 2 transitions. A self-test pass followed by a bus-test fail gives 4.
- R9: Reset applied in any state, including mid-test, returns the sequencer to its reset state and drops the active request.
- R10: rst_short_o rises after the release of a synchronized reset that was high for fewer cycles than its minimum: COLD_MIN (10000) for a cold reset, WARM_MIN (15) for a warm one. It is cleared while reset is active.
- R11: A reset is cold when pwr_good_i was low at any time since the previous reset release, or while that reset was active and power-good had not returned by its release. Every other reset is warm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n_i | input | 1 | Raw asynchronous active-low reset pin |
| pwr_good_i | input | 1 | Power-good indication, selects cold or warm minimum |
| st_en_i | input | 1 | Self-test enable strap, 1 = run internal self-test |
| core_ad_i | input | AD_W | Address/data value driven by the core |
| core_ctl_i | input | CTL_W | Control values driven by the core |
| st_done_i | input | 1 | Self-test engine finished |
| st_pass_i | input | 1 | Self-test engine result, 1 = pass |
| bt_done_i | input | 1 | Bus confidence test finished |
| bt_pass_i | input | 1 | Bus confidence test result, 1 = pass |
| pad_ad_o | output | AD_W | Gated address/data pads |
| pad_ctl_o | output | CTL_W | Gated control pads |
| st_req_o | output | 1 | Self-test request |
| bt_req_o | output | 1 | Bus confidence test request |
| fail_o | output | 1 | Fail status, 1 = asserted |
| run_en_o | output | 1 | Start user code |
| rst_short_o | output | 1 | Last reset pulse was shorter than its minimum |

## Verification
Some rules are checked by assertions on every cycle:
- the two requests are never both high;
- the halted state never leaves except through reset;
- fail is low whenever run is enabled;
- the fail line toggles when a request rises or is answered;
- the pads stay idle whenever run was low;
- the captured strap stays fixed after sampling.

Other behaviour can only be shown by the bench's scenarios:
- the transition counts along each path;
- the synchronizer's latency;
- the strap being ignored after capture;
- spurious done pulses during reset having no effect;
- the cold and warm width decisions, including the power-good drop that turns the next reset into a cold one.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    SQ_RESET    = 3'd0,
    SQ_SAMPLE   = 3'd1,
    SQ_SELFTEST = 3'd2,
    SQ_BUSTEST  = 3'd3,
    SQ_RUN      = 3'd4,
    SQ_HALT     = 3'd5
  } seq_state_t;
endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain = '0;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain[0] <= ~rst_n_i;
    end else begin : g_many
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], ~rst_n_i};
    end
  endgenerate

  assign rst_o = chain[LAST];
endmodule

// File: rtl/rst_seq_width_mon.sv
module rst_seq_width_mon #(
  parameter int COLD_MIN = 10000,
  parameter int WARM_MIN = 15
) (
  input  logic clk,
  input  logic rst_s,
  input  logic pwr_good_i,
  output logic short_o
);
  localparam int CW = $clog2(COLD_MIN + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(COLD_MIN);
  localparam logic [CW-1:0] WARM_LIM = CW'(WARM_MIN);

  logic [CW-1:0] cnt = '0;
  logic          rst_q = 1'b0;
  logic          cold_pend = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst_s;
    if (rst_s) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      short_o <= 1'b0;
    end else begin
      cnt <= '0;
      if (rst_q) begin
        short_o <= cold_pend ? (cnt < CNT_MAX) : (cnt < WARM_LIM);
        if (pwr_good_i) cold_pend <= 1'b0;
      end
    end
    if (!pwr_good_i) cold_pend <= 1'b1;
  end

  // R10
  idle_cnt_zero_chk: assert property (@(posedge clk) disable iff (rst_s)
    (!rst_q) |-> (cnt == '0));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_s,
  input  logic strap_i,
  input  logic st_done_i,
  input  logic st_pass_i,
  input  logic bt_done_i,
  input  logic bt_pass_i,
  output logic st_req_o,
  output logic bt_req_o,
  output logic fail_o,
  output logic run_en_o
);
  seq_state_t state = SQ_RESET;
  logic       strap_q = 1'b0;

  always_ff @(posedge clk) begin
    if (rst_s) begin
      state    <= SQ_RESET;
      st_req_o <= 1'b0;
      bt_req_o <= 1'b0;
      fail_o   <= 1'b1;
      run_en_o <= 1'b0;
    end else begin
      case (state)
        SQ_RESET: begin
          strap_q <= strap_i;
          state   <= SQ_SAMPLE;
        end
        SQ_SAMPLE: state <= strap_q ? SQ_SELFTEST : SQ_BUSTEST;
        SQ_SELFTEST: begin
          if (!st_req_o) begin
            st_req_o <= 1'b1;
            fail_o   <= ~fail_o;
          end else if (st_done_i) begin
            st_req_o <= 1'b0;
            fail_o   <= ~fail_o;
            state    <= st_pass_i ? SQ_BUSTEST : SQ_HALT;
          end
        end
        SQ_BUSTEST: begin
          if (!bt_req_o) begin
            bt_req_o <= 1'b1;
            fail_o   <= ~fail_o;
          end else if (bt_done_i) begin
            bt_req_o <= 1'b0;
            fail_o   <= ~fail_o;
            state    <= bt_pass_i ? SQ_RUN : SQ_HALT;
          end
        end
        SQ_RUN: begin
          fail_o   <= 1'b0;
          run_en_o <= 1'b1;
        end
        SQ_HALT: ;
        default: state <= SQ_HALT;
      endcase
    end
  end

  // R5
  one_req_chk: assert property (@(posedge clk) disable iff (rst_s)
    !(st_req_o && bt_req_o));
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst_s)
    (state == SQ_HALT) |=> (state == SQ_HALT && !run_en_o && fail_o));
  // R7
  run_no_fail_chk: assert property (@(posedge clk) disable iff (rst_s)
    run_en_o |-> !fail_o);
  // R6
  st_start_toggle_chk: assert property (@(posedge clk) disable iff (rst_s)
    $rose(st_req_o) |-> (fail_o != $past(fail_o)));
  // R6
  bt_end_toggle_chk: assert property (@(posedge clk) disable iff (rst_s)
    ($fell(bt_req_o) && !$past(rst_s)) |-> (fail_o != $past(fail_o)));
  // R4
  no_selftest_chk: assert property (@(posedge clk) disable iff (rst_s)
    (state != SQ_RESET && state != SQ_SAMPLE && !strap_q) |-> !st_req_o);
  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst_s)
    (state != SQ_RESET) |=> $stable(strap_q));
endmodule

// File: rtl/rst_seq_gate.sv
module rst_seq_gate #(
  parameter int              AD_W     = 32,
  parameter int              CTL_W    = 8,
  parameter logic [AD_W-1:0]  AD_IDLE  = '0,
  parameter logic [CTL_W-1:0] CTL_IDLE = '1
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic             run_en_i,
  input  logic [AD_W-1:0]  core_ad_i,
  input  logic [CTL_W-1:0] core_ctl_i,
  output logic [AD_W-1:0]  pad_ad_o,
  output logic [CTL_W-1:0] pad_ctl_o
);
  logic pass_thru;
  assign pass_thru = run_en_i && !rst_s;

  always_ff @(posedge clk) begin
    pad_ad_o  <= pass_thru ? core_ad_i  : AD_IDLE;
    pad_ctl_o <= pass_thru ? core_ctl_i : CTL_IDLE;
  end

  // R2
  pads_idle_chk: assert property (@(posedge clk) disable iff (rst_s)
    !run_en_i |=> (pad_ad_o == AD_IDLE && pad_ctl_o == CTL_IDLE));
  // R2
  pads_follow_chk: assert property (@(posedge clk) disable iff (rst_s)
    run_en_i |=> (pad_ad_o == $past(core_ad_i) && pad_ctl_o == $past(core_ctl_i)));
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int               AD_W        = 32,
  parameter int               CTL_W       = 8,
  parameter logic [AD_W-1:0]  AD_IDLE     = '0,
  parameter logic [CTL_W-1:0] CTL_IDLE    = '1,
  parameter int               SYNC_STAGES = 2,
  parameter int               COLD_MIN    = 10000,
  parameter int               WARM_MIN    = 15
) (
  input  logic             clk,
  input  logic             rst_n_i,
  input  logic             pwr_good_i,
  input  logic             st_en_i,
  input  logic [AD_W-1:0]  core_ad_i,
  input  logic [CTL_W-1:0] core_ctl_i,
  input  logic             st_done_i,
  input  logic             st_pass_i,
  input  logic             bt_done_i,
  input  logic             bt_pass_i,
  output logic [AD_W-1:0]  pad_ad_o,
  output logic [CTL_W-1:0] pad_ctl_o,
  output logic             st_req_o,
  output logic             bt_req_o,
  output logic             fail_o,
  output logic             run_en_o,
  output logic             rst_short_o
);
  logic rst_s;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n_i(rst_n_i), .rst_o(rst_s)
  );

  rst_seq_width_mon #(.COLD_MIN(COLD_MIN), .WARM_MIN(WARM_MIN)) i_mon (
    .clk(clk), .rst_s(rst_s), .pwr_good_i(pwr_good_i), .short_o(rst_short_o)
  );

  rst_seq_fsm i_fsm (
    .clk(clk), .rst_s(rst_s), .strap_i(st_en_i),
    .st_done_i(st_done_i), .st_pass_i(st_pass_i),
    .bt_done_i(bt_done_i), .bt_pass_i(bt_pass_i),
    .st_req_o(st_req_o), .bt_req_o(bt_req_o),
    .fail_o(fail_o), .run_en_o(run_en_o)
  );

  rst_seq_gate #(.AD_W(AD_W), .CTL_W(CTL_W), .AD_IDLE(AD_IDLE), .CTL_IDLE(CTL_IDLE)) i_gate (
    .clk(clk), .rst_s(rst_s), .run_en_i(run_en_o),
    .core_ad_i(core_ad_i), .core_ctl_i(core_ctl_i),
    .pad_ad_o(pad_ad_o), .pad_ctl_o(pad_ctl_o)
  );
endmodule

// File: tb/test_rst_seq_top.sv
module test_rst_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int AD_W = 32;
  localparam int CTL_W = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, pwr_good = 1'b0, strap = 1'b0;
  logic [AD_W-1:0] core_ad = 32'hA5A5_0F0F;
  logic [CTL_W-1:0] core_ctl = 8'h3C;
  logic st_done = 1'b0, st_pass = 1'b0, bt_done = 1'b0, bt_pass = 1'b0;
  logic [AD_W-1:0] pad_ad;
  logic [CTL_W-1:0] pad_ctl;
  logic st_req, bt_req, fail, run_en, rst_short;

  rst_seq_top i_rst_seq_top (
    .clk(clk), .rst_n_i(rst_n), .pwr_good_i(pwr_good), .st_en_i(strap),
    .core_ad_i(core_ad), .core_ctl_i(core_ctl),
    .st_done_i(st_done), .st_pass_i(st_pass), .bt_done_i(bt_done), .bt_pass_i(bt_pass),
    .pad_ad_o(pad_ad), .pad_ctl_o(pad_ctl), .st_req_o(st_req), .bt_req_o(bt_req),
    .fail_o(fail), .run_en_o(run_en), .rst_short_o(rst_short)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // engine responder and transition monitor
  logic spur = 1'b0, tog_clr = 1'b1;
  logic rsp_st_pass = 1'b1, rsp_bt_pass = 1'b1;
  int lat = 2, st_cnt = 0, bt_cnt = 0, tog = 0;
  logic fail_prev = 1'b1, st_seen = 1'b0;

  always @(negedge clk) begin
    if (spur) begin
      st_done <= 1'b1; st_pass <= 1'b0; bt_done <= 1'b1; bt_pass <= 1'b0;
      st_cnt = 0; bt_cnt = 0;
    end else begin
      st_done <= 1'b0; bt_done <= 1'b0;
      if (st_req) begin
        if (st_cnt == lat) begin st_done <= 1'b1; st_pass <= rsp_st_pass; st_cnt = 0; end
        else st_cnt++;
      end else st_cnt = 0;
      if (bt_req) begin
        if (bt_cnt == lat) begin bt_done <= 1'b1; bt_pass <= rsp_bt_pass; bt_cnt = 0; end
        else bt_cnt++;
      end else bt_cnt = 0;
    end
    if (tog_clr) begin tog = 0; st_seen = 1'b0; end
    else begin
      if (fail != fail_prev) tog++;
      if (st_req) st_seen = 1'b1;
    end
    fail_prev = fail;
  end

  // warm/cold reset pulse of n cycles with spurious engine answers held meanwhile
  task automatic pulse_reset(int n);
    rst_n = 1'b0; spur = 1'b1; tog_clr = 1'b1;
    step(n - 1);
    spur = 1'b0;
    step(1);
    rst_n = 1'b1; tog_clr = 1'b0;
  endtask

  typedef struct packed {
    logic       strap;
    logic       st_ok;
    logic       bt_ok;
    logic [3:0] lat;
    logic [3:0] exp_tog;
    logic       exp_run;
    logic       exp_st;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 1'b1, 4'd1, 4'd5, 1'b1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 4'd3, 4'd3, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b1, 4'd2, 4'd2, 1'b0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 4'd4, 4'd4, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b0, 4'd0, 4'd2, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 4'd7, 4'd5, 1'b1, 1'b1}
  };

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // cold start: power-good low first, spurious answers during reset (R5)
    spur = 1'b1; strap = 1'b1;
    step(5);
    chk("R1 reset fail", fail, 1); chk("R1 reset run", run_en, 0);
    chk("R5 no req in reset", {st_req, bt_req}, 0);
    chk("R2 idle pads in reset", {pad_ad, pad_ctl}, {32'h0, 8'hFF});
    pwr_good = 1'b1;
    step(10005);
    spur = 1'b0; step(1);
    rst_n = 1'b1; tog_clr = 1'b0;
    step(10);
    chk("R2 pads idle during tests", {pad_ad, pad_ctl}, {32'h0, 8'hFF});
    step(40);
    chk("R10 cold reset long enough", rst_short, 0);
    chk("R7 cold path run", run_en, 1);
    chk("R6 cold path toggles", tog, 5);

    // vector table
    for (int v = 0; v < NV; v++) begin
      strap = VECS[v].strap; rsp_st_pass = VECS[v].st_ok; rsp_bt_pass = VECS[v].bt_ok;
      lat = int'(VECS[v].lat);
      pulse_reset(20);
      step(60);
      chk($sformatf("R7 R8 vec%0d run", v), run_en, VECS[v].exp_run);
      chk($sformatf("R7 R8 vec%0d fail", v), fail, !VECS[v].exp_run);
      chk($sformatf("R6 vec%0d toggles", v), tog, VECS[v].exp_tog);
      chk($sformatf("R4 vec%0d selftest seen", v), st_seen, VECS[v].exp_st);
      chk($sformatf("R8 vec%0d no req after end", v), {st_req, bt_req}, 0);
      chk($sformatf("R10 vec%0d warm ok", v), rst_short, 0);
    end

    // R2: pads follow core one cycle later while running
    rsp_st_pass = 1'b1; rsp_bt_pass = 1'b1; lat = 2; strap = 1'b0;
    pulse_reset(20);
    step(40);
    chk("R2 running", run_en, 1);
    core_ad = 32'h1234_5678; core_ctl = 8'h81;
    step(1);
    chk("R2 pads follow core", {pad_ad, pad_ctl}, {32'h1234_5678, 8'h81});
    core_ad = 32'hDEAD_BEEF; core_ctl = 8'h00;
    step(1);
    chk("R2 pads follow core 2", {pad_ad, pad_ctl}, {32'hDEAD_BEEF, 8'h00});

    // R1: synchronizer latency seen from run
    rst_n = 1'b0; tog_clr = 1'b1;
    step(2);
    chk("R1 sync delay run still high", run_en, 1);
    step(1);
    chk("R1 reset reached run", run_en, 0);
    chk("R1 reset reached fail", fail, 1);
    step(1);
    chk("R2 pads idle after reset", {pad_ad, pad_ctl}, {32'h0, 8'hFF});
    step(20);
    rst_n = 1'b1; tog_clr = 1'b0;

    // R9: reset in the middle of a self-test
    strap = 1'b1; lat = 15;
    pulse_reset(20);
    for (int i = 0; i < 30 && !st_req; i++) step(1);
    chk("R9 selftest running", st_req, 1);
    rst_n = 1'b0; tog_clr = 1'b1;
    step(3);
    chk("R9 request dropped", st_req, 0);
    chk("R9 fail back high", fail, 1);
    step(20);
    lat = 2;
    rst_n = 1'b1; tog_clr = 1'b0;
    step(50);
    chk("R9 clean run after reset", run_en, 1);

    // R3: strap changed after capture is ignored
    strap = 1'b0;
    pulse_reset(20);
    step(8);
    strap = 1'b1;
    step(40);
    chk("R3 strap ignored no selftest", st_seen, 0);
    chk("R3 strap ignored toggles", tog, 3);

    // R10: short warm reset flagged, then cleared during next reset
    pulse_reset(10);
    step(6);
    chk("R10 short warm flagged", rst_short, 1);
    rst_n = 1'b0;
    step(6);
    chk("R10 flag cleared in reset", rst_short, 0);
    step(14);
    rst_n = 1'b1;
    step(6);
    chk("R10 warm 20 ok", rst_short, 0);

    // R11: power-good drop makes the next reset cold
    step(30);
    pwr_good = 1'b0; step(5); pwr_good = 1'b1; step(5);
    pulse_reset(100);
    step(6);
    chk("R11 cold after pwr drop", rst_short, 1);
    pulse_reset(100);
    step(6);
    chk("R11 next reset warm", rst_short, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule